// File: doc/BRIEF.md
# Dual-Channel Serial Command Decoder

This block sits between a simple register bus and the two channels of a serial controller. It decodes writes to each channel's command address. Each command byte carries three things at once: a transmitter enable field, a receiver enable field and a four-bit miscellaneous opcode. The block holds each channel's transmit and receive enable levels and a transmit-line idle force. It also holds two mode registers per channel. Both mode registers share one bus address, and a per-channel pointer picks which one an access reaches.

The outputs feed the rest of the channel logic. The enable levels are steady states. The receiver and transmitter reset pulses each last one cycle. A tagged strobe reports the channel-local opcodes that are not decoded here, and an untagged strobe reports the chip-wide opcodes. Every output is registered, so a bus access sampled at one clock edge shows its effect directly after that edge.

Top module: `uartcmd_top`

## Requirements
- R1: While and after reset, both channels have transmitter and receiver disabled, the transmit idle force is high, both pointers select mode register 1, both mode registers hold 0, read data is 0, and all pulses and strobes are low.
- R2: Bits 1:0 of a command byte written with busAddr=1 drive the addressed channel's transmitter. The code 01 enables it and clears its idle force. The code 10 disables it. The codes 00 and 11 leave both unchanged.
- R3: Bits 3:2 of a command byte drive the addressed channel's receiver. The code 01 enables it, 10 disables it, and 00 and 11 leave it unchanged.
- R4: An access with busAddr=0 while the pointer selects mode register 1 reaches mode register 1 and moves the pointer to mode register 2. Later accesses reach mode register 2 until the pointer is reset.
- R5: Opcode 1 in bits 7:4 returns the channel's pointer to mode register 1.
- R6: Opcode 2 disables the channel receiver and raises rxResetPulse for that channel for exactly one cycle.
- R7: Opcode 3 disables the channel transmitter, raises txResetPulse for one cycle and sets txIdleForce high. The force stays high until a transmitter enable code arrives.
- R8: When a reset opcode and an enable field arrive in the same byte, the reset is applied first and the enable field second. For example, 0x25 leaves the receiver enabled.
- R9: A command or mode access affects only the channel given by busChan.
- R10: Opcodes 4 to 11 raise chanStrobe for one cycle. chanStrobeCode carries the opcode and chanStrobeChan carries the channel.
- R11: Opcodes 12 and 13 raise chipStrobe for one cycle with chipStrobeCode set to the opcode. Opcodes 0, 14 and 15 change no state and raise no pulse or strobe.
- R12: A read (busRd with busWr low) at busAddr=0 puts the selected mode register on busRdata in the next cycle. A read at busAddr=1 returns 0. busRdata otherwise holds its last value. A write takes priority over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | 0 selects the mode address, 1 selects the command address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busChan | input | CHAN_W | Channel select |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| txEnable | output | NUM_CH | Transmitter enable per channel |
| rxEnable | output | NUM_CH | Receiver enable per channel |
| txResetPulse | output | NUM_CH | One-cycle transmitter reset per channel |
| rxResetPulse | output | NUM_CH | One-cycle receiver reset and FIFO flush per channel |
| txIdleForce | output | NUM_CH | Holds the channel's transmit line high |
| modeReg1 | output | NUM_CH*DATA_W | Mode register 1 of each channel, channel 0 in the low byte |
| modeReg2 | output | NUM_CH*DATA_W | Mode register 2 of each channel, channel 0 in the low byte |
| chanStrobe | output | 1 | One-cycle strobe for channel opcodes 4 to 11 |
| chanStrobeCode | output | 4 | Opcode of chanStrobe |
| chanStrobeChan | output | CHAN_W | Channel of chanStrobe |
| chipStrobe | output | 1 | One-cycle strobe for chip opcodes 12 and 13 |
| chipStrobeCode | output | 4 | Opcode of chipStrobe |

## Verification
The bench targets several corner cases and checks each against a reference model. The first is a byte that combines a reset opcode with an enable code: a design that applied the field before the reset would leave the channel disabled after 0x25. The second is the invalid code 11, which a careless decoder treats as enable or disable. The third is the pointer sequence across reads, writes and opcode 1, where a pointer that fails to advance, or that advances only on writes, returns the wrong mode register. The bench also drives back-to-back commands, to catch pulses that stretch past one cycle. It issues commands to one channel and watches the other, to catch decoding that leaks across channels. It sends opcodes 14 and 15, to catch strobes raised on unassigned codes.

// File: rtl/uartcmd_pkg.sv
package uartcmd_pkg;

  localparam int FIELD_W = 2;
  localparam int OP_W    = 4;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CMD  = 1'b1;

  typedef enum logic [FIELD_W-1:0] {
    FLD_KEEP = 2'b00,
    FLD_ON   = 2'b01,
    FLD_OFF  = 2'b10,
    FLD_BAD  = 2'b11
  } fieldCode_e;

  localparam logic [OP_W-1:0] OP_PTR_RST  = 4'd1;
  localparam logic [OP_W-1:0] OP_RX_RST   = 4'd2;
  localparam logic [OP_W-1:0] OP_TX_RST   = 4'd3;
  localparam logic [OP_W-1:0] OP_CH_LO    = 4'd4;
  localparam logic [OP_W-1:0] OP_CH_HI    = 4'd11;
  localparam logic [OP_W-1:0] OP_CHIP_LO  = 4'd12;
  localparam logic [OP_W-1:0] OP_CHIP_HI  = 4'd13;

  // Per-channel strobes passed from control to datapath
  typedef struct packed {
    logic       cmdWr;
    logic       cmdRd;
    logic       modeWr;
    logic       modeRd;
    fieldCode_e txCode;
    fieldCode_e rxCode;
    logic       ptrReset;
    logic       rxReset;
    logic       txReset;
  } chanCtl_t;

  // Apply an enable field to an already reset-adjusted level
  function automatic logic applyField(input logic cur, input fieldCode_e code);
    case (code)
      FLD_ON:  return 1'b1;
      FLD_OFF: return 1'b0;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/uartcmd_ctrl.sv
module uartcmd_ctrl
  import uartcmd_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8,
  parameter int CHAN_W = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busAddr,
  input  logic                    busWr,
  input  logic                    busRd,
  input  logic [CHAN_W-1:0]       busChan,
  input  logic [DATA_W-1:0]       busWdata,
  output chanCtl_t [NUM_CH-1:0]   ctlVec,
  output logic                    chanStrobe,
  output logic [OP_W-1:0]         chanStrobeCode,
  output logic [CHAN_W-1:0]       chanStrobeChan,
  output logic                    chipStrobe,
  output logic [OP_W-1:0]         chipStrobeCode
);

  logic            wrCmd, rdCmd, wrMode, rdMode;
  logic [OP_W-1:0] opCode;
  fieldCode_e      txField, rxField;
  logic            isChanOp, isChipOp;

  assign wrCmd   = busWr && (busAddr == ADDR_CMD);
  assign wrMode  = busWr && (busAddr == ADDR_MODE);
  assign rdCmd   = busRd && !busWr && (busAddr == ADDR_CMD);
  assign rdMode  = busRd && !busWr && (busAddr == ADDR_MODE);
  assign opCode  = busWdata[7:4];
  assign txField = fieldCode_e'(busWdata[1:0]);
  assign rxField = fieldCode_e'(busWdata[3:2]);

  assign isChanOp = (opCode >= OP_CH_LO) && (opCode <= OP_CH_HI);
  assign isChipOp = (opCode >= OP_CHIP_LO) && (opCode <= OP_CHIP_HI);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      logic sel;
      sel = (busChan == CHAN_W'(i));
      ctlVec[i].cmdWr    = wrCmd && sel;
      ctlVec[i].cmdRd    = rdCmd && sel;
      ctlVec[i].modeWr   = wrMode && sel;
      ctlVec[i].modeRd   = rdMode && sel;
      ctlVec[i].txCode   = txField;
      ctlVec[i].rxCode   = rxField;
      ctlVec[i].ptrReset = wrCmd && sel && (opCode == OP_PTR_RST);
      ctlVec[i].rxReset  = wrCmd && sel && (opCode == OP_RX_RST);
      ctlVec[i].txReset  = wrCmd && sel && (opCode == OP_TX_RST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanStrobe     <= 1'b0;
      chanStrobeCode <= '0;
      chanStrobeChan <= '0;
      chipStrobe     <= 1'b0;
      chipStrobeCode <= '0;
    end else begin
      chanStrobe <= wrCmd && isChanOp;
      chipStrobe <= wrCmd && isChipOp;
      if (wrCmd && isChanOp) begin
        chanStrobeCode <= opCode;
        chanStrobeChan <= busChan;
      end
      if (wrCmd && isChipOp) begin
        chipStrobeCode <= opCode;
      end
    end
  end

endmodule

// File: rtl/uartcmd_chan.sv
module uartcmd_chan
  import uartcmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCtl_t          ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic              txEn,
  output logic              rxEn,
  output logic              txPulse,
  output logic              rxPulse,
  output logic              idleForce,
  output logic              ptrSecond,
  output logic [DATA_W-1:0] mr1,
  output logic [DATA_W-1:0] mr2
);

  logic txBase, rxBase, forceBase;
  logic txNext, rxNext, forceNext;

  // Reset opcode first, enable field second
  always_comb begin
    txBase    = ctl.txReset ? 1'b0 : txEn;
    rxBase    = ctl.rxReset ? 1'b0 : rxEn;
    forceBase = ctl.txReset ? 1'b1 : idleForce;
    txNext    = txEn;
    rxNext    = rxEn;
    forceNext = idleForce;
    if (ctl.cmdWr) begin
      txNext    = applyField(txBase, ctl.txCode);
      rxNext    = applyField(rxBase, ctl.rxCode);
      forceNext = (ctl.txCode == FLD_ON) ? 1'b0 : forceBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEn      <= 1'b0;
      rxEn      <= 1'b0;
      idleForce <= 1'b1;
      txPulse   <= 1'b0;
      rxPulse   <= 1'b0;
      ptrSecond <= 1'b0;
      mr1       <= '0;
      mr2       <= '0;
    end else begin
      txEn      <= txNext;
      rxEn      <= rxNext;
      idleForce <= forceNext;
      txPulse   <= ctl.txReset;
      rxPulse   <= ctl.rxReset;
      if (ctl.modeWr) begin
        if (ptrSecond) mr2 <= wdata;
        else           mr1 <= wdata;
      end
      if (ctl.ptrReset)                       ptrSecond <= 1'b0;
      else if (ctl.modeWr || ctl.modeRd)      ptrSecond <= 1'b1;
    end
  end

endmodule

// File: rtl/uartcmd_datapath.sv
module uartcmd_datapath
  import uartcmd_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  chanCtl_t [NUM_CH-1:0]      ctlVec,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic [NUM_CH-1:0]          txEnable,
  output logic [NUM_CH-1:0]          rxEnable,
  output logic [NUM_CH-1:0]          txResetPulse,
  output logic [NUM_CH-1:0]          rxResetPulse,
  output logic [NUM_CH-1:0]          txIdleForce,
  output logic [NUM_CH*DATA_W-1:0]   modeReg1,
  output logic [NUM_CH*DATA_W-1:0]   modeReg2
);

  logic [NUM_CH-1:0] ptrSecond;
  logic [DATA_W-1:0] selData [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    uartcmd_chan #(.DATA_W(DATA_W)) uChan (
      .clk       (clk),
      .rstN      (rstN),
      .ctl       (ctlVec[i]),
      .wdata     (busWdata),
      .txEn      (txEnable[i]),
      .rxEn      (rxEnable[i]),
      .txPulse   (txResetPulse[i]),
      .rxPulse   (rxResetPulse[i]),
      .idleForce (txIdleForce[i]),
      .ptrSecond (ptrSecond[i]),
      .mr1       (modeReg1[i*DATA_W +: DATA_W]),
      .mr2       (modeReg2[i*DATA_W +: DATA_W])
    );
    assign selData[i] = ptrSecond[i] ? modeReg2[i*DATA_W +: DATA_W]
                                     : modeReg1[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctlVec[i].modeRd) busRdata <= selData[i];
        if (ctlVec[i].cmdRd)  busRdata <= '0;
      end
    end
  end

endmodule

// File: rtl/uartcmd_top.sv
module uartcmd_top
  import uartcmd_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8,
  parameter int CHAN_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busAddr,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [CHAN_W-1:0]        busChan,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic [NUM_CH-1:0]        txEnable,
  output logic [NUM_CH-1:0]        rxEnable,
  output logic [NUM_CH-1:0]        txResetPulse,
  output logic [NUM_CH-1:0]        rxResetPulse,
  output logic [NUM_CH-1:0]        txIdleForce,
  output logic [NUM_CH*DATA_W-1:0] modeReg1,
  output logic [NUM_CH*DATA_W-1:0] modeReg2,
  output logic                     chanStrobe,
  output logic [3:0]               chanStrobeCode,
  output logic [CHAN_W-1:0]        chanStrobeChan,
  output logic                     chipStrobe,
  output logic [3:0]               chipStrobeCode
);

  chanCtl_t [NUM_CH-1:0] ctlVec;

  uartcmd_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .busAddr        (busAddr),
    .busWr          (busWr),
    .busRd          (busRd),
    .busChan        (busChan),
    .busWdata       (busWdata),
    .ctlVec         (ctlVec),
    .chanStrobe     (chanStrobe),
    .chanStrobeCode (chanStrobeCode),
    .chanStrobeChan (chanStrobeChan),
    .chipStrobe     (chipStrobe),
    .chipStrobeCode (chipStrobeCode)
  );

  uartcmd_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .ctlVec       (ctlVec),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .txEnable     (txEnable),
    .rxEnable     (rxEnable),
    .txResetPulse (txResetPulse),
    .rxResetPulse (rxResetPulse),
    .txIdleForce  (txIdleForce),
    .modeReg1     (modeReg1),
    .modeReg2     (modeReg2)
  );

endmodule

// File: rtl/uartcmd_checker.sv
module uartcmd_checker #(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8,
  parameter int CHAN_W = 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busAddr,
  input logic                     busWr,
  input logic [CHAN_W-1:0]        busChan,
  input logic [DATA_W-1:0]        busWdata,
  input logic [NUM_CH-1:0]        txEnable,
  input logic [NUM_CH-1:0]        rxEnable,
  input logic [NUM_CH-1:0]        txResetPulse,
  input logic [NUM_CH-1:0]        rxResetPulse,
  input logic [NUM_CH-1:0]        txIdleForce,
  input logic                     chanStrobe,
  input logic [CHAN_W-1:0]        chanStrobeChan,
  input logic                     chipStrobe
);

  logic cmdWrIn;
  assign cmdWrIn = busWr && busAddr;

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    a_r2_tx_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
      $rose(txEnable[i]) |-> $past(cmdWrIn && busChan == CHAN_W'(i) && busWdata[1:0] == 2'b01));

    a_r3_rx_rise_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rxEnable[i]) |-> $past(cmdWrIn && busChan == CHAN_W'(i) && busWdata[3:2] == 2'b01));

    // R6 and R8: a receiver reset leaves it off unless the same byte enabled it
    a_r6_rx_reset_disables: assert property (@(posedge clk) disable iff (!rstN)
      (rxResetPulse[i] && !$past(busWdata[3:2] == 2'b01)) |-> !rxEnable[i]);

    a_r7_force_on_reset: assert property (@(posedge clk) disable iff (!rstN)
      (txResetPulse[i] && !$past(busWdata[1:0] == 2'b01)) |-> (txIdleForce[i] && !txEnable[i]));

    a_r7_force_release: assert property (@(posedge clk) disable iff (!rstN)
      $fell(txIdleForce[i]) |-> txEnable[i]);

    a_r9_pulse_channel: assert property (@(posedge clk) disable iff (!rstN)
      (rxResetPulse[i] || txResetPulse[i]) |-> $past(cmdWrIn && busChan == CHAN_W'(i)));
  end

  a_r10_chan_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    chanStrobe |-> ($past(cmdWrIn && busWdata[7:4] >= 4'd4 && busWdata[7:4] <= 4'd11)
                    && chanStrobeChan == $past(busChan)));

  a_r11_chip_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    chipStrobe |-> $past(cmdWrIn && (busWdata[7:4] == 4'd12 || busWdata[7:4] == 4'd13)));

endmodule

bind uartcmd_top uartcmd_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) chk (
  .clk            (clk),
  .rstN           (rstN),
  .busAddr        (busAddr),
  .busWr          (busWr),
  .busChan        (busChan),
  .busWdata       (busWdata),
  .txEnable       (txEnable),
  .rxEnable       (rxEnable),
  .txResetPulse   (txResetPulse),
  .rxResetPulse   (rxResetPulse),
  .txIdleForce    (txIdleForce),
  .chanStrobe     (chanStrobe),
  .chanStrobeChan (chanStrobeChan),
  .chipStrobe     (chipStrobe)
);

// File: tb/tb_uartcmd_top.sv
module tb_uartcmd_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 8;
  localparam int CHAN_W = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [CHAN_W-1:0] busChan = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [NUM_CH-1:0] txEnable, rxEnable, txResetPulse, rxResetPulse, txIdleForce;
  logic [NUM_CH*DATA_W-1:0] modeReg1, modeReg2;
  logic chanStrobe, chipStrobe;
  logic [3:0] chanStrobeCode, chipStrobeCode;
  logic [CHAN_W-1:0] chanStrobeChan;

  always #(CLK_PERIOD/2) clk = ~clk;

  uartcmd_top #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busChan(busChan), .busWdata(busWdata), .busRdata(busRdata),
    .txEnable(txEnable), .rxEnable(rxEnable), .txResetPulse(txResetPulse),
    .rxResetPulse(rxResetPulse), .txIdleForce(txIdleForce),
    .modeReg1(modeReg1), .modeReg2(modeReg2), .chanStrobe(chanStrobe),
    .chanStrobeCode(chanStrobeCode), .chanStrobeChan(chanStrobeChan),
    .chipStrobe(chipStrobe), .chipStrobeCode(chipStrobeCode));

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  // Reference model state
  logic [NUM_CH-1:0] eTx, eRx, eTxP, eRxP, eForce, ePtr;
  logic [DATA_W-1:0] eMr1 [NUM_CH];
  logic [DATA_W-1:0] eMr2 [NUM_CH];
  logic [DATA_W-1:0] eRd;
  logic eCs, eChip;
  logic [3:0] eCsCode, eChipCode;
  logic [CHAN_W-1:0] eCsChan;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic fieldNext(input logic cur, input logic [1:0] code);
    if (code == 2'b01) return 1'b1;
    if (code == 2'b10) return 1'b0;
    return cur;
  endfunction

  task automatic modelReset();
    eTx = '0; eRx = '0; eTxP = '0; eRxP = '0; eForce = '1; ePtr = '0;
    for (int i = 0; i < NUM_CH; i++) begin eMr1[i] = '0; eMr2[i] = '0; end
    eRd = '0; eCs = 1'b0; eChip = 1'b0;
  endtask

  task automatic modelStep(input logic a, input logic w, input logic r,
                           input logic [CHAN_W-1:0] ch, input logic [7:0] d);
    logic [3:0] op;
    op = d[7:4];
    eTxP = '0; eRxP = '0; eCs = 1'b0; eChip = 1'b0;
    if (w && a) begin
      if (op == 4'd1) ePtr[ch] = 1'b0;
      if (op == 4'd2) begin eRx[ch] = 1'b0; eRxP[ch] = 1'b1; end
      if (op == 4'd3) begin eTx[ch] = 1'b0; eTxP[ch] = 1'b1; eForce[ch] = 1'b1; end
      eTx[ch] = fieldNext(eTx[ch], d[1:0]);
      if (d[1:0] == 2'b01) eForce[ch] = 1'b0;
      eRx[ch] = fieldNext(eRx[ch], d[3:2]);
      if (op >= 4'd4 && op <= 4'd11) begin eCs = 1'b1; eCsCode = op; eCsChan = ch; end
      if (op == 4'd12 || op == 4'd13) begin eChip = 1'b1; eChipCode = op; end
    end else if (w && !a) begin
      if (ePtr[ch]) eMr2[ch] = d; else eMr1[ch] = d;
      ePtr[ch] = 1'b1;
    end else if (r && !a) begin
      eRd = ePtr[ch] ? eMr2[ch] : eMr1[ch];
      ePtr[ch] = 1'b1;
    end else if (r && a) begin
      eRd = '0;
    end
  endtask

  task automatic compareAll(input string tag);
    check(txEnable == eTx, {tag, "/R2 txEnable"}, txEnable, eTx);
    check(rxEnable == eRx, {tag, "/R3 rxEnable"}, rxEnable, eRx);
    check(rxResetPulse == eRxP, {tag, "/R6 rxResetPulse"}, rxResetPulse, eRxP);
    check(txResetPulse == eTxP, {tag, "/R7 txResetPulse"}, txResetPulse, eTxP);
    check(txIdleForce == eForce, {tag, "/R7 txIdleForce"}, txIdleForce, eForce);
    check(busRdata == eRd, {tag, "/R12 busRdata"}, busRdata, eRd);
    for (int i = 0; i < NUM_CH; i++) begin
      check(modeReg1[i*DATA_W +: DATA_W] == eMr1[i], {tag, "/R4 modeReg1"},
            modeReg1[i*DATA_W +: DATA_W], eMr1[i]);
      check(modeReg2[i*DATA_W +: DATA_W] == eMr2[i], {tag, "/R4 modeReg2"},
            modeReg2[i*DATA_W +: DATA_W], eMr2[i]);
    end
    check(chanStrobe == eCs, {tag, "/R10 chanStrobe"}, chanStrobe, eCs);
    if (eCs) begin
      check(chanStrobeCode == eCsCode, {tag, "/R10 chanStrobeCode"}, chanStrobeCode, eCsCode);
      check(chanStrobeChan == eCsChan, {tag, "/R10 chanStrobeChan"}, chanStrobeChan, eCsChan);
    end
    check(chipStrobe == eChip, {tag, "/R11 chipStrobe"}, chipStrobe, eChip);
    if (eChip)
      check(chipStrobeCode == eChipCode, {tag, "/R11 chipStrobeCode"}, chipStrobeCode, eChipCode);
  endtask

  // Called at a falling edge; drives one access, crosses one rising edge, checks
  task automatic busOp(input string tag, input logic a, input logic w, input logic r,
                       input logic [CHAN_W-1:0] ch, input logic [7:0] d);
    busAddr = a; busWr = w; busRd = r; busChan = ch; busWdata = d;
    modelStep(a, w, r, ch, d);
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    compareAll(tag);
  endtask

  task automatic cmdW(input string tag, input logic [CHAN_W-1:0] ch, input logic [7:0] d);
    busOp(tag, 1'b1, 1'b1, 1'b0, ch, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");
    check(txIdleForce == 2'b11, "R1 idle force", txIdleForce, 2'b11);

    // Enable fields, invalid code, isolation
    cmdW("R2 tx on", 1'b0, 8'h01);
    cmdW("R2 tx code 11 ignored", 1'b0, 8'h03);
    cmdW("R3 rx on", 1'b0, 8'h04);
    cmdW("R3 rx code 11 ignored", 1'b0, 8'h0C);
    check(txEnable[1] == 1'b0 && rxEnable[1] == 1'b0, "R9 channel 1 untouched",
          {txEnable[1], rxEnable[1]}, 0);
    cmdW("R9 ch1 tx on", 1'b1, 8'h01);
    cmdW("R3 rx off", 1'b0, 8'h08);
    cmdW("R2 tx off", 1'b0, 8'h02);

    // Reset opcodes, back to back, and ordering
    cmdW("R6 rx reset", 1'b1, 8'h20);
    cmdW("R6 rx reset again", 1'b1, 8'h20);
    cmdW("R8 rx reset plus enable", 1'b1, 8'h25);
    check(rxEnable[1] == 1'b1, "R8 rx enabled after 0x25", rxEnable[1], 1);
    cmdW("R7 tx reset", 1'b1, 8'h30);
    check(txIdleForce[1] == 1'b1, "R7 force set", txIdleForce[1], 1);
    cmdW("R7 tx reset plus enable", 1'b1, 8'h31);
    busOp("R6 idle clears pulses", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    // Mode pointer
    busOp("R4 mode write 1", 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5);
    busOp("R4 mode write 2", 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A);
    busOp("R4 mode write stays 2", 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C);
    busOp("R12 read mode", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    cmdW("R5 pointer reset", 1'b0, 8'h10);
    busOp("R5 read reaches mr1", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    check(busRdata == 8'hA5, "R5 mr1 value", busRdata, 8'hA5);
    busOp("R4 read advanced", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    busOp("R9 ch1 mode write", 1'b0, 1'b1, 1'b0, 1'b1, 8'h77);
    busOp("R12 cmd read zero", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    busOp("R12 write wins over read", 1'b0, 1'b1, 1'b1, 1'b1, 8'h66);

    // Strobes and no-effect opcodes
    cmdW("R10 op 4", 1'b0, 8'h40);
    cmdW("R10 op B", 1'b1, 8'hB0);
    cmdW("R11 op C", 1'b1, 8'hC0);
    cmdW("R11 op D", 1'b0, 8'hD0);
    cmdW("R11 op E no effect", 1'b0, 8'hE0);
    cmdW("R11 op F no effect", 1'b1, 8'hF0);
    cmdW("R11 op 0 no effect", 1'b0, 8'h00);

    // Constrained random traffic
    for (int n = 0; n < 2000; n++) begin
      int kind;
      logic [7:0] d;
      logic ch;
      kind = $urandom % 8;
      d = 8'($urandom);
      ch = 1'($urandom);
      case (kind)
        0, 1, 2, 3: busOp("RND cmd", 1'b1, 1'b1, 1'($urandom), ch, d);
        4:          busOp("RND mode wr", 1'b0, 1'b1, 1'b0, ch, d);
        5:          busOp("RND mode rd", 1'b0, 1'b0, 1'b1, ch, d);
        6:          busOp("RND cmd rd", 1'b1, 1'b0, 1'b1, ch, d);
        default:    busOp("RND idle", 1'($urandom), 1'b0, 1'b0, ch, d);
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule